// File: doc/BRIEF.md
# Dependency Token Synchronizer for Three Concurrent Engines

This block keeps a load engine, a compute engine and a store engine in order while they run side by side. It holds four one-way token counters: load→compute (loaded data may be consumed), compute→load (a buffer is free to be refilled), compute→store (results may be written out) and store→compute (the accumulator region was saved and may be reused). Nothing else orders the three engines.

Each engine talks to the block through two handshakes. The start handshake carries the instruction's pop flags. The block raises the ready signal only when the engine is idle and every queue it names holds a token. Both pops are then taken in the same cycle. The completion handshake carries the push flags. It is accepted only while the engine has an instruction in flight and every queue it names has room. A held start or completion is back-pressure: the engine keeps valid and its flags steady until ready rises. Counts, overflow flags and busy flags are plain status outputs.

Queue index order on the status buses is fixed: 0 load→compute, 1 compute→load, 2 compute→store, 3 store→compute. Engine index order on `eng_busy` is 0 load, 1 compute, 2 store.

Top module: `dep_token_sync`

## Requirements
- R1: After reset, all four counts (`q_count`) are 0, all four `q_ovf` bits are 0 and all three `eng_busy` bits are 0.
- R2: An accepted completion with a push flag adds one token to the named queue, seen on `q_count` after the next rising edge. The mapping is: load push → index 0; compute push_ld → index 1; compute push_st → index 2; store push → index 3.
- R3: A start that asks to pop from a queue whose count is 0, when no token enters that queue in the same cycle, is held with ready low. The count is unchanged.
- R4: A compute start that asks for both pops is granted only when both queues 0 and 3 can supply a token. When granted, both counts drop by one at the same edge. When either is missing, neither count changes.
- R5: When a push and a pop hit the same queue in the same cycle, the count is unchanged and the pop is granted, even if the count was 0.
- R6: No count ever exceeds DEPTH. A completion that would push into a full queue is held with done ready low. Room freed by a pop in the same cycle does not count. The count stays at DEPTH.
- R7: A completion held by a full queue sets that queue's `q_ovf` bit at the next edge. The bit stays set until reset.
- R8: Each engine has at most one instruction in flight. Start ready is low while that engine is busy. Done ready is low while it is idle, and a completion offered then changes no count.
- R9: A start with no pop flags is granted at once when the engine is idle. A completion with no push flags is accepted while busy and leaves all counts unchanged.
- R10: Ready outputs respond in the same cycle as their valid and flag inputs. Counts, overflow bits and busy bits change only at a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req_valid | input | 1 | Load engine wants to start an instruction |
| ld_req_pop | input | 1 | Start needs a token from compute→load |
| ld_req_ready | output | 1 | Load start granted |
| ld_done_valid | input | 1 | Load engine finished its instruction |
| ld_done_push | input | 1 | Completion pushes to load→compute |
| ld_done_ready | output | 1 | Load completion accepted |
| cp_req_valid | input | 1 | Compute engine wants to start |
| cp_req_pop_ld | input | 1 | Start needs a token from load→compute |
| cp_req_pop_st | input | 1 | Start needs a token from store→compute |
| cp_req_ready | output | 1 | Compute start granted |
| cp_done_valid | input | 1 | Compute engine finished |
| cp_done_push_ld | input | 1 | Completion pushes to compute→load |
| cp_done_push_st | input | 1 | Completion pushes to compute→store |
| cp_done_ready | output | 1 | Compute completion accepted |
| st_req_valid | input | 1 | Store engine wants to start |
| st_req_pop | input | 1 | Start needs a token from compute→store |
| st_req_ready | output | 1 | Store start granted |
| st_done_valid | input | 1 | Store engine finished |
| st_done_push | input | 1 | Completion pushes to store→compute |
| st_done_ready | output | 1 | Store completion accepted |
| q_count | output | 4 x clog2(DEPTH+1) | Token count per queue |
| q_ovf | output | 4 | Sticky push-into-full flag per queue |
| eng_busy | output | 3 | Instruction in flight per engine |

## Verification
Any corruption of a token counter shows on `q_count` at the edge after it happens. It also shows through the ready signals: a counter stuck at zero holds a consumer forever, and one that went too high grants a start with no real token. A lost busy flag shows up at once, either as a start ready while the engine is busy or as a completion ready while it is idle. A reference model checks each ready in every cycle and the counts after every edge, so a fault is found within one cycle of the first stimulus that exposes it. Directed sequences force the empty-stall, dual-pop, same-cycle bypass and full-queue cases. Random traffic then mixes them.

// File: rtl/dep_sync_pkg.sv
package dep_sync_pkg;
  localparam int NUM_Q   = 4;
  localparam int NUM_ENG = 3;

  // queue slots on the status buses
  localparam int Q_L2C = 0;
  localparam int Q_C2L = 1;
  localparam int Q_C2S = 2;
  localparam int Q_S2C = 3;

  // engine slots on the busy bus
  localparam int E_LD = 0;
  localparam int E_CP = 1;
  localparam int E_ST = 2;
endpackage

// File: rtl/dep_token_ctr.sv
// One directional semaphore: saturating token count with a same-cycle bypass.
module dep_token_ctr #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,        // committed push this cycle
  input  logic          pop,         // granted pop this cycle
  input  logic          push_stall,  // producer blocked by a full count
  output logic [CW-1:0] count,
  output logic          avail,       // a token can be taken this cycle
  output logic          room,        // a push can be taken this cycle
  output logic          ovf
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  assign avail = (count != '0) || push;
  assign room  = (count != FULL_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
      if (push_stall)        ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/dep_engine_gate.sv
// Per-engine gate: one instruction in flight, atomic pops before start,
// atomic pushes on completion.
module dep_engine_gate #(
  parameter int NSLOT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [NSLOT-1:0] req_pop,
  input  logic [NSLOT-1:0] tok_avail,
  output logic             req_ready,
  output logic [NSLOT-1:0] pop_take,
  input  logic             done_valid,
  input  logic [NSLOT-1:0] done_push,
  input  logic [NSLOT-1:0] q_room,
  output logic             done_ready,
  output logic [NSLOT-1:0] push_put,
  output logic [NSLOT-1:0] push_stall,
  output logic             busy
);
  logic req_fire, done_fire;
  logic [NSLOT-1:0] pop_ok, push_ok;

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign pop_ok[s]     = !req_pop[s] || tok_avail[s];
      assign push_ok[s]    = !done_push[s] || q_room[s];
      assign pop_take[s]   = req_fire && req_pop[s];
      assign push_put[s]   = done_fire && done_push[s];
      assign push_stall[s] = busy && done_valid && done_push[s] && !q_room[s];
    end
  endgenerate

  assign req_ready  = !busy && (&pop_ok);
  assign done_ready = busy && (&push_ok);
  assign req_fire   = req_valid && req_ready;
  assign done_fire  = done_valid && done_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)         busy <= 1'b0;
    else if (req_fire)  busy <= 1'b1;
    else if (done_fire) busy <= 1'b0;
  end
endmodule

// File: rtl/dep_token_sync.sv
module dep_token_sync
  import dep_sync_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_req_valid,
  input  logic ld_req_pop,
  output logic ld_req_ready,
  input  logic ld_done_valid,
  input  logic ld_done_push,
  output logic ld_done_ready,
  input  logic cp_req_valid,
  input  logic cp_req_pop_ld,
  input  logic cp_req_pop_st,
  output logic cp_req_ready,
  input  logic cp_done_valid,
  input  logic cp_done_push_ld,
  input  logic cp_done_push_st,
  output logic cp_done_ready,
  input  logic st_req_valid,
  input  logic st_req_pop,
  output logic st_req_ready,
  input  logic st_done_valid,
  input  logic st_done_push,
  output logic st_done_ready,
  output logic [3:0][$clog2(DEPTH+1)-1:0] q_count,
  output logic [3:0] q_ovf,
  output logic [2:0] eng_busy
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [NUM_Q-1:0] q_push, q_pop, q_stall, q_avail, q_room;

  // load engine: pops compute->load, pushes load->compute
  logic [0:0] ld_take, ld_put, ld_stall;
  dep_engine_gate #(.NSLOT(1)) u_ld_gate (
    .clk(clk), .rst_n(rst_n),
    .req_valid(ld_req_valid), .req_pop(ld_req_pop), .tok_avail(q_avail[Q_C2L]),
    .req_ready(ld_req_ready), .pop_take(ld_take),
    .done_valid(ld_done_valid), .done_push(ld_done_push), .q_room(q_room[Q_L2C]),
    .done_ready(ld_done_ready), .push_put(ld_put), .push_stall(ld_stall),
    .busy(eng_busy[E_LD])
  );

  // compute engine: slot 0 faces load, slot 1 faces store
  logic [1:0] cp_take, cp_put, cp_stall;
  dep_engine_gate #(.NSLOT(2)) u_cp_gate (
    .clk(clk), .rst_n(rst_n),
    .req_valid(cp_req_valid), .req_pop({cp_req_pop_st, cp_req_pop_ld}),
    .tok_avail({q_avail[Q_S2C], q_avail[Q_L2C]}),
    .req_ready(cp_req_ready), .pop_take(cp_take),
    .done_valid(cp_done_valid), .done_push({cp_done_push_st, cp_done_push_ld}),
    .q_room({q_room[Q_C2S], q_room[Q_C2L]}),
    .done_ready(cp_done_ready), .push_put(cp_put), .push_stall(cp_stall),
    .busy(eng_busy[E_CP])
  );

  // store engine: pops compute->store, pushes store->compute
  logic [0:0] st_take, st_put, st_stall;
  dep_engine_gate #(.NSLOT(1)) u_st_gate (
    .clk(clk), .rst_n(rst_n),
    .req_valid(st_req_valid), .req_pop(st_req_pop), .tok_avail(q_avail[Q_C2S]),
    .req_ready(st_req_ready), .pop_take(st_take),
    .done_valid(st_done_valid), .done_push(st_done_push), .q_room(q_room[Q_S2C]),
    .done_ready(st_done_ready), .push_put(st_put), .push_stall(st_stall),
    .busy(eng_busy[E_ST])
  );

  // producer / consumer routing per queue
  assign q_push[Q_L2C]  = ld_put[0];
  assign q_pop[Q_L2C]   = cp_take[0];
  assign q_stall[Q_L2C] = ld_stall[0];

  assign q_push[Q_C2L]  = cp_put[0];
  assign q_pop[Q_C2L]   = ld_take[0];
  assign q_stall[Q_C2L] = cp_stall[0];

  assign q_push[Q_C2S]  = cp_put[1];
  assign q_pop[Q_C2S]   = st_take[0];
  assign q_stall[Q_C2S] = cp_stall[1];

  assign q_push[Q_S2C]  = st_put[0];
  assign q_pop[Q_S2C]   = cp_take[1];
  assign q_stall[Q_S2C] = st_stall[0];

  generate
    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      logic [CW-1:0] cnt;
      dep_token_ctr #(.DEPTH(DEPTH)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .push(q_push[q]), .pop(q_pop[q]), .push_stall(q_stall[q]),
        .count(cnt), .avail(q_avail[q]), .room(q_room[q]), .ovf(q_ovf[q])
      );
      assign q_count[q] = cnt;
    end
  endgenerate
endmodule

// File: rtl/dep_token_sync_chk.sv
module dep_token_sync_chk #(
  parameter int DEPTH = 4
) (
  input logic clk,
  input logic rst_n,
  input logic ld_req_valid, ld_req_pop, ld_req_ready,
  input logic ld_done_valid, ld_done_push, ld_done_ready,
  input logic cp_req_valid, cp_req_pop_ld, cp_req_pop_st, cp_req_ready,
  input logic cp_done_valid, cp_done_push_ld, cp_done_push_st, cp_done_ready,
  input logic st_req_valid, st_req_pop, st_req_ready,
  input logic st_done_valid, st_done_push, st_done_ready,
  input logic [3:0][$clog2(DEPTH+1)-1:0] q_count,
  input logic [3:0] q_ovf,
  input logic [2:0] eng_busy
);
  logic ld_put, cp_put_ld, cp_put_st, st_put;
  assign ld_put    = ld_done_valid && ld_done_ready && ld_done_push;
  assign cp_put_ld = cp_done_valid && cp_done_ready && cp_done_push_ld;
  assign cp_put_st = cp_done_valid && cp_done_ready && cp_done_push_st;
  assign st_put    = st_done_valid && st_done_ready && st_done_push;

  generate
    for (genvar g = 0; g < 4; g++) begin : g_q
      AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_count[g]) <= DEPTH); // R6
      AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(q_count[g]) <= int'($past(q_count[g])) + 1) &&
        (int'(q_count[g]) + 1 >= int'($past(q_count[g])))); // R2
      AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        q_ovf[g] |=> q_ovf[g]); // R7
    end
  endgenerate

  AST_EMPTY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req_pop && q_count[1] == '0 && !cp_put_ld) |-> !ld_req_ready); // R3
  AST_ATOMIC_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_req_valid && cp_req_ready && cp_req_pop_ld && cp_req_pop_st) |->
    ((q_count[0] != '0 || ld_put) && (q_count[3] != '0 || st_put))); // R4
  AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_put && cp_req_valid && cp_req_ready && cp_req_pop_ld) |=>
    (q_count[0] == $past(q_count[0]))); // R5
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_done_push && int'(q_count[0]) == DEPTH) |-> !ld_done_ready); // R6
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_req_ready && ld_done_ready) && !(cp_req_ready && cp_done_ready) &&
    !(st_req_ready && st_done_ready)); // R8
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy[2] |-> !st_done_ready); // R8
endmodule

bind dep_token_sync dep_token_sync_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ld_req_valid(ld_req_valid), .ld_req_pop(ld_req_pop), .ld_req_ready(ld_req_ready),
  .ld_done_valid(ld_done_valid), .ld_done_push(ld_done_push), .ld_done_ready(ld_done_ready),
  .cp_req_valid(cp_req_valid), .cp_req_pop_ld(cp_req_pop_ld), .cp_req_pop_st(cp_req_pop_st),
  .cp_req_ready(cp_req_ready), .cp_done_valid(cp_done_valid), .cp_done_push_ld(cp_done_push_ld),
  .cp_done_push_st(cp_done_push_st), .cp_done_ready(cp_done_ready),
  .st_req_valid(st_req_valid), .st_req_pop(st_req_pop), .st_req_ready(st_req_ready),
  .st_done_valid(st_done_valid), .st_done_push(st_done_push), .st_done_ready(st_done_ready),
  .q_count(q_count), .q_ovf(q_ovf), .eng_busy(eng_busy)
);

// File: tb/sim_dep_token_sync.sv
`timescale 1ns/1ps
module sim_dep_token_sync;
  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic ld_req_valid, ld_req_pop, ld_done_valid, ld_done_push;
  logic cp_req_valid, cp_req_pop_ld, cp_req_pop_st, cp_done_valid, cp_done_push_ld, cp_done_push_st;
  logic st_req_valid, st_req_pop, st_done_valid, st_done_push;
  logic ld_req_ready, ld_done_ready, cp_req_ready, cp_done_ready, st_req_ready, st_done_ready;
  logic [3:0][CW-1:0] q_count;
  logic [3:0] q_ovf;
  logic [2:0] eng_busy;

  dep_token_sync #(.DEPTH(DEPTH)) u0 (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  int m_cnt[4];
  bit m_busy[3];
  bit m_ovf[4];
  bit e_lrr, e_ldr, e_crr, e_cdr, e_srr, e_sdr;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_in();
    {ld_req_valid, ld_req_pop, ld_done_valid, ld_done_push} = '0;
    {cp_req_valid, cp_req_pop_ld, cp_req_pop_st, cp_done_valid, cp_done_push_ld, cp_done_push_st} = '0;
    {st_req_valid, st_req_pop, st_done_valid, st_done_push} = '0;
  endtask

  function automatic bit full(int q);
    return m_cnt[q] == DEPTH;
  endfunction

  bit p[4], pp[4], st[4];
  // combinational expectations from the requirements (R3 R4 R5 R6 R8 R9)
  task automatic model_eval();
    e_ldr = m_busy[0] && !(ld_done_push && full(0));
    e_cdr = m_busy[1] && !(cp_done_push_ld && full(1)) && !(cp_done_push_st && full(2));
    e_sdr = m_busy[2] && !(st_done_push && full(3));
    p[0] = ld_done_valid && e_ldr && ld_done_push;
    p[1] = cp_done_valid && e_cdr && cp_done_push_ld;
    p[2] = cp_done_valid && e_cdr && cp_done_push_st;
    p[3] = st_done_valid && e_sdr && st_done_push;
    e_lrr = !m_busy[0] && (!ld_req_pop || m_cnt[1] != 0 || p[1]);
    e_crr = !m_busy[1] && (!cp_req_pop_ld || m_cnt[0] != 0 || p[0])
                       && (!cp_req_pop_st || m_cnt[3] != 0 || p[3]);
    e_srr = !m_busy[2] && (!st_req_pop || m_cnt[2] != 0 || p[2]);
    pp[0] = cp_req_valid && e_crr && cp_req_pop_ld;
    pp[1] = ld_req_valid && e_lrr && ld_req_pop;
    pp[2] = st_req_valid && e_srr && st_req_pop;
    pp[3] = cp_req_valid && e_crr && cp_req_pop_st;
    st[0] = m_busy[0] && ld_done_valid && ld_done_push && full(0);
    st[1] = m_busy[1] && cp_done_valid && cp_done_push_ld && full(1);
    st[2] = m_busy[1] && cp_done_valid && cp_done_push_st && full(2);
    st[3] = m_busy[2] && st_done_valid && st_done_push && full(3);
  endtask

  task automatic settle();
    #1;
    model_eval();
    chk(ld_req_ready == e_lrr, "R3/R8 ld_req_ready", ld_req_ready, e_lrr);
    chk(cp_req_ready == e_crr, "R4/R8 cp_req_ready", cp_req_ready, e_crr);
    chk(st_req_ready == e_srr, "R3/R8 st_req_ready", st_req_ready, e_srr);
    chk(ld_done_ready == e_ldr, "R6/R8 ld_done_ready", ld_done_ready, e_ldr);
    chk(cp_done_ready == e_cdr, "R6/R8 cp_done_ready", cp_done_ready, e_cdr);
    chk(st_done_ready == e_sdr, "R6/R8 st_done_ready", st_done_ready, e_sdr);
  endtask

  task automatic advance();
    @(posedge clk);
    for (int q = 0; q < 4; q++) begin
      m_cnt[q] = m_cnt[q] + int'(p[q]) - int'(pp[q]);
      if (st[q]) m_ovf[q] = 1;
    end
    if (ld_req_valid && e_lrr) m_busy[0] = 1; else if (ld_done_valid && e_ldr) m_busy[0] = 0;
    if (cp_req_valid && e_crr) m_busy[1] = 1; else if (cp_done_valid && e_cdr) m_busy[1] = 0;
    if (st_req_valid && e_srr) m_busy[2] = 1; else if (st_done_valid && e_sdr) m_busy[2] = 0;
    #1;
    for (int q = 0; q < 4; q++) begin
      chk(int'(q_count[q]) == m_cnt[q], "R2/R10 q_count", int'(q_count[q]), m_cnt[q]);
      chk(q_ovf[q] == m_ovf[q], "R7 q_ovf", q_ovf[q], m_ovf[q]);
    end
    for (int e = 0; e < 3; e++)
      chk(eng_busy[e] == m_busy[e], "R8 eng_busy", eng_busy[e], m_busy[e]);
  endtask

  task automatic model_reset();
    for (int q = 0; q < 4; q++) begin m_cnt[q] = 0; m_ovf[q] = 0; end
    for (int e = 0; e < 3; e++) m_busy[e] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_in();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int q = 0; q < 4; q++) begin
      chk(q_count[q] == '0, "R1 count after reset", int'(q_count[q]), 0);
      chk(q_ovf[q] == 1'b0, "R1/R7 ovf after reset", q_ovf[q], 0);
    end
    chk(eng_busy == 3'b000, "R1 busy after reset", eng_busy, 0);
  endtask

  // one cycle of stimulus: drive at negedge, check readies, then the edge
  task automatic cyc();
    settle();
    advance();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    idle_in();
    model_reset();
    do_reset();

    // R3: load pops an empty compute->load queue and stalls
    @(negedge clk); idle_in(); ld_req_valid = 1; ld_req_pop = 1;
    settle(); chk(ld_req_ready == 0, "R3 empty pop stalls", ld_req_ready, 0); advance();
    chk(q_count[1] == '0, "R3 count unchanged", int'(q_count[1]), 0);

    // R9: start with no pop granted at once
    @(negedge clk); idle_in(); ld_req_valid = 1;
    settle(); chk(ld_req_ready == 1, "R9 no-pop start", ld_req_ready, 1); advance();
    // R2: load completion pushes queue 0
    @(negedge clk); idle_in(); ld_done_valid = 1; ld_done_push = 1;
    cyc(); chk(q_count[0] == CW'(1), "R2 load push to index 0", int'(q_count[0]), 1);

    // R4: dual pop with store->compute empty is held, nothing taken
    @(negedge clk); idle_in(); cp_req_valid = 1; cp_req_pop_ld = 1; cp_req_pop_st = 1;
    settle(); chk(cp_req_ready == 0, "R4 dual pop held", cp_req_ready, 0); advance();
    chk(q_count[0] == CW'(1), "R4 no partial pop", int'(q_count[0]), 1);
    // single pop granted
    @(negedge clk); idle_in(); cp_req_valid = 1; cp_req_pop_ld = 1;
    cyc(); chk(q_count[0] == '0, "R4 single pop taken", int'(q_count[0]), 0);

    // R5: load pushes while compute pops the empty queue in the same cycle
    @(negedge clk); idle_in(); ld_req_valid = 1; cp_done_valid = 1;  // R9 no-push done
    cyc();
    @(negedge clk); idle_in(); ld_done_valid = 1; ld_done_push = 1; cp_req_valid = 1; cp_req_pop_ld = 1;
    settle(); chk(cp_req_ready == 1, "R5 bypass grant", cp_req_ready, 1); advance();
    chk(q_count[0] == '0, "R5 count unchanged", int'(q_count[0]), 0);
    @(negedge clk); idle_in(); cp_done_valid = 1; cyc();

    // R6/R7: fill queue 0, then one more push is held
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); idle_in(); ld_req_valid = 1; cyc();
      @(negedge clk); idle_in(); ld_done_valid = 1; ld_done_push = 1; cyc();
    end
    chk(int'(q_count[0]) == DEPTH, "R6 full count", int'(q_count[0]), DEPTH);
    @(negedge clk); idle_in(); ld_req_valid = 1; cyc();
    @(negedge clk); idle_in(); ld_done_valid = 1; ld_done_push = 1;
    settle(); chk(ld_done_ready == 0, "R6 push into full held", ld_done_ready, 0); advance();
    chk(int'(q_count[0]) == DEPTH, "R6 count saturates", int'(q_count[0]), DEPTH);
    chk(q_ovf[0] == 1, "R7 ovf set", q_ovf[0], 1);

    // R8: start while busy held; completion while idle ignored
    @(negedge clk); idle_in(); ld_req_valid = 1; st_done_valid = 1; st_done_push = 1;
    settle();
    chk(ld_req_ready == 0, "R8 start while busy", ld_req_ready, 0);
    chk(st_done_ready == 0, "R8 done while idle", st_done_ready, 0);
    advance();
    chk(q_count[3] == '0, "R8 idle done no push", int'(q_count[3]), 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      ld_req_valid = $urandom_range(0, 1); ld_req_pop = $urandom_range(0, 1);
      ld_done_valid = $urandom_range(0, 1); ld_done_push = ($urandom_range(0, 3) != 0);
      cp_req_valid = $urandom_range(0, 1); cp_req_pop_ld = $urandom_range(0, 1);
      cp_req_pop_st = $urandom_range(0, 1);
      cp_done_valid = $urandom_range(0, 1); cp_done_push_ld = $urandom_range(0, 1);
      cp_done_push_st = $urandom_range(0, 1);
      st_req_valid = $urandom_range(0, 1); st_req_pop = $urandom_range(0, 1);
      st_done_valid = $urandom_range(0, 1); st_done_push = $urandom_range(0, 1);
      cyc();
    end

    // R7: only reset clears the overflow flags
    do_reset();

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule